// File: doc/BRIEF.md
# ISA 8-bit I/O Cycle Sequencer

This block runs single-byte I/O read and write transfers on an ISA-style expansion bus on behalf of a host. The host presents an address, a direction, and a write byte for writes, then pulses `start`. The sequencer latches the request. It puts the address on the bus and pulses the address latch strobe. It then asserts the read or write command strobe for a timed interval and releases it. The address, direction and data-buffer controls stay in place for a short hold afterwards. Finally it pulses `done` for one clock, and on a read `rdData` carries the byte taken from the bus.

Each interval is a whole number of 50 ns base ticks, and the block advances one tick per clock. Reads and writes have different setup, strobe-width and hold counts. A slow peripheral can pull the ready line low to stretch the command. The ready line passes through a two-flop synchronizer. Once it returns high, the strobe stays active for a further post-ready interval that depends on the direction. A write can also push back the strobe's start so that the data bus is driven for the full data-setup time before the strobe ends.

Top module: `isa_io_seq`

## Requirements
- R1: While `rstN` is low, `iorN`, `iowN` and `bufOeN` are 1, and `bale`, `done`, `enDirHi`, `enDirLo` and `isaDataDrv` are 0.
- R2: `bale` is high for exactly one clock, which is the first clock after `start` is accepted. Neither strobe is active in that clock. The command strobe asserts a fixed number of clocks after the first `bale` clock: 3 for a read, and for a write the larger of 4 and the data-setup count (8) minus the write strobe width.
- R3: `isaAddr` equals the accepted `addrIn` from the `bale` clock through the clock before `done`, and it does not change while a strobe is active.
- R4: With the ready line held high, `iorN` is low for exactly 11 clocks and `iowN` is low for exactly 9 clocks. The two strobes are never low together.
- R5: If `ioChRdy` is low during the first W clocks of the strobe (W ≥ 1), the strobe stays low for max(base width, W + 3 + P) clocks, where P is 4 on a read and 3 on a write. A strobe is released only when `ioChRdy` was high three clocks earlier.
- R6: `bufOeN` is 0 in every clock in which a strobe is low, and in every hold clock after the strobe is released.
- R7: On a read, `enDirHi` and `enDirLo` are 1 from the `bale` clock through the last hold clock, which covers every clock in which `iorN` is low. On a write both stay 0.
- R8: On a write, `isaDataDrv` is 1 and `isaDataOut` equals the accepted `wrData` from the `bale` clock through the hold clock. On a read, `isaDataDrv` stays 0.
- R9: On a read, `rdData` shown with `done` equals the `isaDataIn` value present in the last clock of the `iorN` strobe.
- R10: After the strobe is released there are 3 hold clocks on a read and 1 on a write. Then `done` is high for exactly one clock.
- R11: A `start` pulse arriving while a transfer is in progress is ignored. It produces no `bale`, no extra `done` and no change to the bus address or data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one clock per 50 ns timing tick |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request pulse, accepted only when idle |
| isWrite | input | 1 | 1 selects a write transfer, 0 a read |
| addrIn | input | ADDR_W | I/O address of the request |
| wrData | input | DATA_W | Byte to write |
| done | output | 1 | One-clock completion pulse |
| rdData | output | DATA_W | Byte captured on the last read |
| isaAddr | output | ADDR_W | Bus address |
| bale | output | 1 | Address latch strobe, active high |
| iorN | output | 1 | I/O read command, active low |
| iowN | output | 1 | I/O write command, active low |
| bufOeN | output | 1 | Data buffer output enable, active low |
| enDirHi | output | 1 | High byte lane direction, 1 = toward host |
| enDirLo | output | 1 | Low byte lane direction, 1 = toward host |
| ioChRdy | input | 1 | Peripheral ready, low stretches the command |
| isaDataIn | input | DATA_W | Bus data from the peripheral |
| isaDataOut | output | DATA_W | Bus data to the peripheral |
| isaDataDrv | output | 1 | Enable for driving `isaDataOut` onto the bus |

## Verification
A phase counter that runs off by one shows up at once as a setup, strobe-width or hold count one clock off. It is seen in the same transfer in which it happens, and at the latest when `done` arrives. A slip in the synchronized-ready or post-ready logic appears only in stretched transfers. There the strobe is released too early, too late, or while the ready line is still low. If the latched direction or request registers are corrupted, the wrong strobe fires, the direction lines are wrong, or a busy `start` starts a second `bale`. Each of these can be seen within one transfer.

// File: rtl/isa_io_pkg.sv
package isa_io_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_ADDR,
    S_CMD,
    S_WAIT,
    S_HOLD,
    S_DONE
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic load;
    logic bale;
    logic ior;
    logic iow;
    logic bufOe;
    logic rdDir;
    logic drvWr;
    logic capture;
    logic done;
  } seqCtl_t;

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/isa_io_ctrl.sv
module isa_io_ctrl
  import isa_io_pkg::*;
#(
  parameter int SETUP_RD   = 3,
  parameter int SETUP_WR   = 4,
  parameter int PULSE_RD   = 11,
  parameter int PULSE_WR   = 9,
  parameter int POST_RD    = 4,
  parameter int POST_WR    = 3,
  parameter int HOLD_RD    = 3,
  parameter int HOLD_WR    = 1,
  parameter int DSU_WR     = 8,
  parameter int BALE_TICKS = 1
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    start,
  input  logic    isWrite,
  input  logic    rdySync,
  output seqCtl_t ctl
);

  // write setup stretched so data setup fits before the strobe ends
  localparam int SetupWrEff = imax(SETUP_WR, DSU_WR - PULSE_WR);
  localparam int MaxTicks   = imax(imax(SetupWrEff, SETUP_RD),
                                   imax(imax(PULSE_WR, PULSE_RD),
                                        imax(imax(POST_WR, POST_RD),
                                             imax(HOLD_WR, HOLD_RD))));
  localparam int CntW = $clog2(MaxTicks + 1);

  localparam logic [CntW-1:0] SetupRdL  = CntW'(SETUP_RD - 1);
  localparam logic [CntW-1:0] SetupWrL  = CntW'(SetupWrEff - 1);
  localparam logic [CntW-1:0] PulseRdL  = CntW'(PULSE_RD - 1);
  localparam logic [CntW-1:0] PulseWrL  = CntW'(PULSE_WR - 1);
  localparam logic [CntW-1:0] HoldRdL   = CntW'(HOLD_RD - 1);
  localparam logic [CntW-1:0] HoldWrL   = CntW'(HOLD_WR - 1);
  localparam logic [CntW-1:0] PostRdV   = CntW'(POST_RD);
  localparam logic [CntW-1:0] PostWrV   = CntW'(POST_WR);
  localparam logic [CntW-1:0] BaleRdMin = CntW'(SETUP_RD - BALE_TICKS);
  localparam logic [CntW-1:0] BaleWrMin = CntW'(SetupWrEff - BALE_TICKS);

  seqState_t       state;
  logic [CntW-1:0] cnt;
  logic [CntW-1:0] postCnt;
  logic            dirWr;
  logic            inCmd;
  logic            release_;

  assign inCmd    = (state == S_CMD) || (state == S_WAIT);
  assign release_ = inCmd && (cnt == '0) && rdySync && (postCnt == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= S_IDLE;
      cnt     <= '0;
      postCnt <= '0;
      dirWr   <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (start) begin
          state <= S_ADDR;
          dirWr <= isWrite;
          cnt   <= isWrite ? SetupWrL : SetupRdL;
        end
        S_ADDR: if (cnt == '0) begin
          state   <= S_CMD;
          cnt     <= dirWr ? PulseWrL : PulseRdL;
          postCnt <= '0;
        end else begin
          cnt <= cnt - 1'b1;
        end
        S_CMD, S_WAIT: begin
          if (!rdySync)             postCnt <= dirWr ? PostWrV : PostRdV;
          else if (postCnt != '0)   postCnt <= postCnt - 1'b1;
          if (release_) begin
            state <= S_HOLD;
            cnt   <= dirWr ? HoldWrL : HoldRdL;
          end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
          end else begin
            state <= S_WAIT;
          end
        end
        S_HOLD: if (cnt == '0) state <= S_DONE;
                else           cnt   <= cnt - 1'b1;
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    ctl         = '0;
    ctl.load    = (state == S_IDLE) && start;
    ctl.bale    = (state == S_ADDR) && (cnt >= (dirWr ? BaleWrMin : BaleRdMin));
    ctl.ior     = inCmd && !dirWr;
    ctl.iow     = inCmd && dirWr;
    ctl.bufOe   = inCmd || (state == S_HOLD);
    ctl.rdDir   = !dirWr && (state inside {S_ADDR, S_CMD, S_WAIT, S_HOLD});
    ctl.drvWr   = dirWr && (state inside {S_ADDR, S_CMD, S_WAIT, S_HOLD});
    ctl.capture = release_ && !dirWr;
    ctl.done    = (state == S_DONE);
  end

endmodule

// File: rtl/isa_io_dp.sv
module isa_io_dp
  import isa_io_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqCtl_t           ctl,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic [DATA_W-1:0] wrData,
  input  logic              ioChRdy,
  input  logic [DATA_W-1:0] isaDataIn,
  output logic              rdySync,
  output logic [DATA_W-1:0] rdData,
  output logic              done,
  output logic [ADDR_W-1:0] isaAddr,
  output logic              bale,
  output logic              iorN,
  output logic              iowN,
  output logic              bufOeN,
  output logic              enDirHi,
  output logic              enDirLo,
  output logic [DATA_W-1:0] isaDataOut,
  output logic              isaDataDrv
);

  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] wrQ;
  logic [DATA_W-1:0] rdQ;
  logic              rdyMeta;
  logic              rdyQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdyMeta <= 1'b1;
      rdyQ    <= 1'b1;
    end else begin
      rdyMeta <= ioChRdy;
      rdyQ    <= rdyMeta;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ <= '0;
      wrQ   <= '0;
      rdQ   <= '0;
    end else begin
      if (ctl.load) begin
        addrQ <= addrIn;
        wrQ   <= wrData;
      end
      if (ctl.capture) rdQ <= isaDataIn;
    end
  end

  assign rdySync    = rdyQ;
  assign rdData     = rdQ;
  assign done       = ctl.done;
  assign isaAddr    = addrQ;
  assign bale       = ctl.bale;
  assign iorN       = !ctl.ior;
  assign iowN       = !ctl.iow;
  assign bufOeN     = !ctl.bufOe;
  assign enDirHi    = ctl.rdDir;
  assign enDirLo    = ctl.rdDir;
  assign isaDataOut = ctl.drvWr ? wrQ : '0;
  assign isaDataDrv = ctl.drvWr;

endmodule

// File: rtl/isa_io_seq.sv
module isa_io_seq
  import isa_io_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 8,
  parameter int SETUP_RD   = 3,
  parameter int SETUP_WR   = 4,
  parameter int PULSE_RD   = 11,
  parameter int PULSE_WR   = 9,
  parameter int POST_RD    = 4,
  parameter int POST_WR    = 3,
  parameter int HOLD_RD    = 3,
  parameter int HOLD_WR    = 1,
  parameter int DSU_WR     = 8,
  parameter int BALE_TICKS = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              isWrite,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic [DATA_W-1:0] wrData,
  output logic              done,
  output logic [DATA_W-1:0] rdData,
  output logic [ADDR_W-1:0] isaAddr,
  output logic              bale,
  output logic              iorN,
  output logic              iowN,
  output logic              bufOeN,
  output logic              enDirHi,
  output logic              enDirLo,
  input  logic              ioChRdy,
  input  logic [DATA_W-1:0] isaDataIn,
  output logic [DATA_W-1:0] isaDataOut,
  output logic              isaDataDrv
);

  seqCtl_t ctl;
  logic    rdySync;

  isa_io_ctrl #(
    .SETUP_RD(SETUP_RD), .SETUP_WR(SETUP_WR),
    .PULSE_RD(PULSE_RD), .PULSE_WR(PULSE_WR),
    .POST_RD(POST_RD),   .POST_WR(POST_WR),
    .HOLD_RD(HOLD_RD),   .HOLD_WR(HOLD_WR),
    .DSU_WR(DSU_WR),     .BALE_TICKS(BALE_TICKS)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .isWrite(isWrite),
    .rdySync(rdySync), .ctl(ctl)
  );

  isa_io_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .addrIn(addrIn), .wrData(wrData),
    .ioChRdy(ioChRdy), .isaDataIn(isaDataIn), .rdySync(rdySync),
    .rdData(rdData), .done(done), .isaAddr(isaAddr), .bale(bale),
    .iorN(iorN), .iowN(iowN), .bufOeN(bufOeN), .enDirHi(enDirHi),
    .enDirLo(enDirLo), .isaDataOut(isaDataOut), .isaDataDrv(isaDataDrv)
  );

endmodule

// File: rtl/isa_io_chk.sv
module isa_io_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              done,
  input logic [ADDR_W-1:0] isaAddr,
  input logic              bale,
  input logic              iorN,
  input logic              iowN,
  input logic              bufOeN,
  input logic              enDirHi,
  input logic              enDirLo,
  input logic              ioChRdy,
  input logic              isaDataDrv
);

  assert_bale_strobe_idle_R2: assert property (@(posedge clk) disable iff (!rstN)
    bale |-> (iorN && iowN));

  assert_addr_steady_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!iorN || !iowN) |=> $stable(isaAddr));

  assert_one_strobe_R4: assert property (@(posedge clk) disable iff (!rstN)
    (iorN || iowN));

  assert_release_on_ready_R5: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(iorN) || $rose(iowN)) |-> $past(ioChRdy, 3));

  assert_buf_during_cmd_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!iorN || !iowN) |-> !bufOeN);

  assert_buf_after_cmd_R6: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(iorN) || $rose(iowN)) |-> !bufOeN);

  assert_dir_on_read_R7: assert property (@(posedge clk) disable iff (!rstN)
    !iorN |-> (enDirHi && enDirLo));

  assert_drive_on_write_R8: assert property (@(posedge clk) disable iff (!rstN)
    !iowN |-> (isaDataDrv && !enDirLo));

  assert_done_single_R10: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

endmodule

bind isa_io_seq isa_io_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .done(done), .isaAddr(isaAddr), .bale(bale),
  .iorN(iorN), .iowN(iowN), .bufOeN(bufOeN), .enDirHi(enDirHi),
  .enDirLo(enDirLo), .ioChRdy(ioChRdy), .isaDataDrv(isaDataDrv)
);

// File: tb/tb_isa_io_seq.sv
module tb_isa_io_seq;

  typedef struct {
    bit      wr;
    int      addr;
    int      data;
    int      setup;
    int      width;
    int      hold;
  } expItem_t;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic        isWrite = 1'b0;
  logic [15:0] addrIn = '0;
  logic [7:0]  wrData = '0;
  logic        done;
  logic [7:0]  rdData;
  logic [15:0] isaAddr;
  logic        bale, iorN, iowN, bufOeN, enDirHi, enDirLo;
  logic        ioChRdy = 1'b1;
  logic [7:0]  isaDataIn = '0;
  logic [7:0]  isaDataOut;
  logic        isaDataDrv;

  int testsRun = 0;
  int testsFailed = 0;
  int curW = 0;
  bit finished = 1'b0;

  expItem_t q[$];

  always #4 clk = ~clk;

  isa_io_seq dut (
    .clk(clk), .rstN(rstN), .start(start), .isWrite(isWrite),
    .addrIn(addrIn), .wrData(wrData), .done(done), .rdData(rdData),
    .isaAddr(isaAddr), .bale(bale), .iorN(iorN), .iowN(iowN),
    .bufOeN(bufOeN), .enDirHi(enDirHi), .enDirLo(enDirLo),
    .ioChRdy(ioChRdy), .isaDataIn(isaDataIn), .isaDataOut(isaDataOut),
    .isaDataDrv(isaDataDrv)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // peripheral model: ready held low for curW clocks from strobe start
  bit perSeen = 1'b0;
  int perIdx = 0;
  always @(negedge clk) begin
    if (rstN && (!iorN || !iowN)) begin
      if (!perSeen) begin
        perSeen = 1'b1;
        perIdx = 0;
        if (curW > 0) ioChRdy = 1'b0;
      end else begin
        perIdx++;
      end
      if (perIdx == curW) ioChRdy = 1'b1;
    end else begin
      perSeen = 1'b0;
    end
  end

  // monitor / scoreboard
  bit inCyc = 1'b0;
  bit strobeSeen = 1'b0;
  int setupCnt = 0, widthCnt = 0, holdCnt = 0;
  int lastRd = 0;
  expItem_t cur;
  always @(negedge clk) begin
    if (rstN) begin
      if (bale && inCyc) check(1'b0, "R11 second bale in transfer", 1, 0);
      if (bale && !inCyc) begin
        if (q.size() == 0) begin
          check(1'b0, "R11 bale without accepted request", 1, 0);
        end else begin
          cur = q[0];
          inCyc = 1'b1; strobeSeen = 1'b0;
          setupCnt = 0; widthCnt = 0; holdCnt = 0;
          check(int'(isaAddr) == cur.addr, "R3 address at bale", isaAddr, cur.addr);
        end
      end
      if (inCyc && !done) begin
        if (!iorN || !iowN) begin
          strobeSeen = 1'b1;
          widthCnt++;
          lastRd = isaDataIn;
          if (cur.wr && !iowN && widthCnt == 1) begin
            check(isaDataDrv && int'(isaDataOut) == cur.data, "R8 write data on bus",
                  isaDataOut, cur.data);
            check(!enDirHi && !enDirLo, "R7 no read direction on write", enDirLo, 0);
          end
          if (!cur.wr && widthCnt == 1) begin
            check(!isaDataDrv, "R8 no drive on read", isaDataDrv, 0);
            check(enDirHi && enDirLo, "R7 read direction", enDirLo, 1);
          end
          if (cur.wr == iowN) check(1'b0, "R4 wrong strobe", iowN, !cur.wr);
        end else if (!strobeSeen) begin
          setupCnt++;
        end else begin
          holdCnt++;
          check(!bufOeN, "R6 buffer enable in hold", bufOeN, 0);
          check(int'(isaAddr) == cur.addr, "R3 address in hold", isaAddr, cur.addr);
          if (!cur.wr) check(enDirLo && enDirHi, "R7 direction in hold", enDirLo, 1);
        end
      end
      if (done) begin
        if (!inCyc) begin
          check(1'b0, "R11 done without transfer", 1, 0);
        end else begin
          void'(q.pop_front());
          inCyc = 1'b0;
          check(setupCnt == cur.setup, "R2 setup clocks", setupCnt, cur.setup);
          check(widthCnt == cur.width,
                cur.width == 9 || cur.width == 11 ? "R4 strobe width" : "R5 stretched width",
                widthCnt, cur.width);
          check(holdCnt == cur.hold, "R10 hold clocks", holdCnt, cur.hold);
          if (!cur.wr) begin
            check(int'(rdData) == lastRd && lastRd == cur.data, "R9 read byte",
                  rdData, cur.data);
          end
        end
      end
    end
  end

  task automatic doTxn(input bit wr, input int addr, input int data,
                       input int w, input bit pokeBusy);
    expItem_t e;
    int pulse, post;
    pulse = wr ? 9 : 11;
    post  = wr ? 3 : 4;
    e.wr = wr; e.addr = addr; e.data = data;
    e.setup = wr ? 4 : 3;
    e.hold  = wr ? 1 : 3;
    e.width = (w == 0) ? pulse : ((w + 3 + post > pulse) ? w + 3 + post : pulse);
    curW = w;
    @(negedge clk);
    isWrite = wr; addrIn = 16'(addr); wrData = 8'(data);
    isaDataIn = wr ? 8'h00 : 8'(data);
    q.push_back(e);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (pokeBusy) begin
      repeat (5) @(negedge clk);
      start = 1'b1; isWrite = !wr; addrIn = 16'h0155; wrData = 8'hEE;
      @(negedge clk);
      start = 1'b0;
    end
    while (q.size() != 0 || inCyc) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(iorN && iowN && bufOeN, "R1 reset strobes", {iorN, iowN, bufOeN}, 3'b111);
    check(!bale && !done && !enDirHi && !enDirLo && !isaDataDrv, "R1 reset outputs",
          {bale, done, enDirHi, enDirLo, isaDataDrv}, 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    doTxn(1'b0, 16'h03F8, 8'hA5, 0, 1'b0);   // R4 plain read
    doTxn(1'b1, 16'h02E8, 8'h5C, 0, 1'b0);   // R4 plain write
    doTxn(1'b1, 16'h0378, 8'h3C, 6, 1'b0);   // R5 write stretched to 12
    doTxn(1'b0, 16'h0060, 8'h96, 10, 1'b0);  // R5 read stretched to 17
    doTxn(1'b0, 16'h0201, 8'h0F, 1, 1'b0);   // R5 short low, base width wins
    doTxn(1'b1, 16'h0330, 8'hC3, 0, 1'b1);   // R11 busy start on write
    doTxn(1'b0, 16'h0388, 8'h7E, 0, 1'b1);   // R11 busy start on read
    repeat (30) @(negedge clk);
    check(q.size() == 0 && !inCyc, "R11 no extra transfer", q.size(), 0);
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

endmodule